// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds recently used virtual-to-physical page translations for a 32-bit processor. Each lookup presents a virtual address and a privilege flag. In the same cycle, the virtual page number is compared against every stored entry in parallel. The block then reports one of three results:

- a hit, with the translated physical address;
- a miss, which goes to the exception unit so it can restart the faulting instruction;
- a protection fault, when user code touches the kernel half of the address space.

Pages are 4 KB. Bits 31:12 of an address form the page number and bits 11:0 form the offset, which passes through unchanged. Once the miss handler has found the translation, it writes it through a refill port.

Each entry keeps a small reference counter. A hit sets the counter of the entry that hit to its maximum and ages every other counter. A refill chooses its slot in this order:

1. the entry already holding the same page number;
2. otherwise, the lowest-numbered empty entry;
3. otherwise, the entry with the smallest counter.

One cycle after a refill is written, a restart pulse tells the exception unit to reissue the instruction.

Top module: `xlat_buf`

## Requirements
- R1: After reset every entry is invalid. Any enabled lookup then reports a miss, and restart_o is low.
- R2: On a hit, hit_o rises in the same cycle as the request. paddr_o is {stored physical page, vaddr_i[11:0]}, and dirty_o shows the stored dirty bit.
- R3: An enabled lookup in a permitted region whose page number matches no valid entry raises miss_o, with paddr_o = 0 and dirty_o = 0.
- R4: When user_mode_i = 1 and vaddr_i[31] = 1, an enabled lookup raises fault_o and neither hit_o nor miss_o, even if a valid entry matches. With user_mode_i = 0, the same address hits.
- R5: hit_o, miss_o and fault_o are mutually exclusive. All three are low when lookup_en_i is low.
- R6: In a cycle with a hit and no refill, the counter of the hit entry becomes 2^REF_W-1 and every other counter decrements, saturating at 0. A miss, fault or idle cycle changes no counter.
- R7: A refill writes its entry valid with counter 2^REF_W-1 and leaves the other counters unchanged. Its slot is the valid entry with the same page number if one exists. Otherwise it is the lowest-indexed invalid entry. Otherwise it is the entry with the smallest counter, the lowest index winning ties.
- R8: restart_o is high in exactly the cycle after a cycle with refill_en_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_en_i | input | 1 | Lookup request |
| vaddr_i | input | 32 | Virtual address |
| user_mode_i | input | 1 | 1 = user privilege |
| paddr_o | output | 32 | Translated physical address, 0 unless hit |
| hit_o | output | 1 | Translation found |
| miss_o | output | 1 | No translation; request to exception unit |
| fault_o | output | 1 | User access to kernel region refused |
| dirty_o | output | 1 | Dirty bit of the hit entry |
| refill_en_i | input | 1 | Write a new translation |
| refill_vpn_i | input | 20 | Virtual page number to write |
| refill_ppn_i | input | 20 | Physical page number to write |
| refill_dirty_i | input | 1 | Dirty bit to write |
| restart_o | output | 1 | Restart pulse to exception unit after refill |

## Verification
The bench targets the eviction order once the buffer is full. A design that got this wrong would evict a recently hit page, or break counter ties toward a higher index, and a later lookup of the surviving page would miss.

It also refills a page number that is already resident. A buffer without the duplicate search would keep the stale translation, or hold two matching entries and return a mixed physical page.

Kernel pages are probed from user mode after a successful tag match. A design that checked the tag before the privilege would report a hit there.

Counter aging is checked under long mixed sequences of hits, misses and refills. An off-by-one in saturation would change which entry is chosen as the victim.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = 20;
  localparam int PA_W  = PPN_W + OFF_W;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
  import xlat_pkg::*;
#(
  parameter int N     = 48,
  parameter int REF_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [VPN_W-1:0]           lk_vpn_i,
  input  logic [VPN_W-1:0]           rf_vpn_i,
  output logic [N-1:0]               lk_match_o,
  output logic [N-1:0]               rf_match_o,
  output logic [PPN_W-1:0]           hit_ppn_o,
  output logic                       hit_dirty_o,
  output logic [IDX_W-1:0]           hit_idx_o,
  input  logic                       age_en_i,
  input  logic                       we_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [PPN_W-1:0]           wr_ppn_i,
  input  logic                       wr_dirty_i,
  output logic [N-1:0]               valid_o,
  output logic [N-1:0][REF_W-1:0]    ref_o
);
  localparam logic [REF_W-1:0] REF_MAX = '1;

  logic [VPN_W-1:0] vpn_q   [N];
  logic [PPN_W-1:0] ppn_q   [N];
  logic [REF_W-1:0] ref_q   [N];
  logic [N-1:0]     valid_q;
  logic [N-1:0]     dirty_q;

  for (genvar e = 0; e < N; e++) begin : g_entry
    logic sel;
    assign sel = we_i && (wr_idx_i == IDX_W'(e));
    assign lk_match_o[e] = valid_q[e] && (vpn_q[e] == lk_vpn_i);
    assign rf_match_o[e] = valid_q[e] && (vpn_q[e] == rf_vpn_i);
    assign ref_o[e] = ref_q[e];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[e] <= 1'b0;
        dirty_q[e] <= 1'b0;
        vpn_q[e]   <= '0;
        ppn_q[e]   <= '0;
        ref_q[e]   <= '0;
      end else if (sel) begin
        valid_q[e] <= 1'b1;
        dirty_q[e] <= wr_dirty_i;
        vpn_q[e]   <= rf_vpn_i;
        ppn_q[e]   <= wr_ppn_i;
        ref_q[e]   <= REF_MAX;
      end else if (!we_i && age_en_i) begin
        if (lk_match_o[e])       ref_q[e] <= REF_MAX;
        else if (ref_q[e] != '0) ref_q[e] <= ref_q[e] - 1'b1;
      end
    end
  end

  assign valid_o = valid_q;

  // one-hot read mux; uniqueness of matches is kept by refill dedupe
  always_comb begin
    hit_ppn_o   = '0;
    hit_dirty_o = 1'b0;
    hit_idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match_o[i]) begin
        hit_ppn_o   = hit_ppn_o | ppn_q[i];
        hit_dirty_o = hit_dirty_o | dirty_q[i];
        hit_idx_o   = hit_idx_o | IDX_W'(i);
      end
    end
  end

  assert_onehot_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match_o));

  assert_refill_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> valid_q[$past(wr_idx_i)] && (vpn_q[$past(wr_idx_i)] == $past(rf_vpn_i))
             && (ref_q[$past(wr_idx_i)] == REF_MAX));

  assert_hit_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_en_i && !we_i) |=> ref_q[$past(hit_idx_o)] == REF_MAX);
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N     = 48,
  parameter int REF_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0]            rf_match_i,
  input  logic [N-1:0][REF_W-1:0] ref_i,
  output logic [IDX_W-1:0]        victim_o
);
  logic             dup_f, inv_f, low_f;
  logic [IDX_W-1:0] dup_idx, inv_idx, low_idx;
  logic [REF_W-1:0] low_ref;

  always_comb begin
    dup_f   = 1'b0;
    inv_f   = 1'b0;
    low_f   = 1'b0;
    dup_idx = '0;
    inv_idx = '0;
    low_idx = '0;
    low_ref = '1;
    for (int i = 0; i < N; i++) begin
      if (rf_match_i[i]) begin
        dup_f   = 1'b1;
        dup_idx = IDX_W'(i);
      end
      if (!valid_i[i] && !inv_f) begin
        inv_f   = 1'b1;
        inv_idx = IDX_W'(i);
      end
      // strict compare keeps the lowest index on ties
      if (!low_f || ref_i[i] < low_ref) begin
        low_f   = 1'b1;
        low_ref = ref_i[i];
        low_idx = IDX_W'(i);
      end
    end
    if (dup_f)      victim_o = dup_idx;
    else if (inv_f) victim_o = inv_idx;
    else            victim_o = low_idx;
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int N     = 48,
  parameter int REF_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_en_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             user_mode_i,
  output logic [PA_W-1:0]  paddr_o,
  output logic             hit_o,
  output logic             miss_o,
  output logic             fault_o,
  output logic             dirty_o,
  input  logic             refill_en_i,
  input  logic [VPN_W-1:0] refill_vpn_i,
  input  logic [PPN_W-1:0] refill_ppn_i,
  input  logic             refill_dirty_i,
  output logic             restart_o
);
  logic [N-1:0]            lk_match, rf_match, valid;
  logic [N-1:0][REF_W-1:0] refs;
  logic [PPN_W-1:0]        hit_ppn;
  logic                    hit_dirty;
  logic [IDX_W-1:0]        hit_idx, victim;
  logic                    kern_blk, any_hit, restart_q;

  xlat_cam #(.N(N), .REF_W(REF_W)) u_cam (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_vpn_i    (vaddr_i[VA_W-1:OFF_W]),
    .rf_vpn_i    (refill_vpn_i),
    .lk_match_o  (lk_match),
    .rf_match_o  (rf_match),
    .hit_ppn_o   (hit_ppn),
    .hit_dirty_o (hit_dirty),
    .hit_idx_o   (hit_idx),
    .age_en_i    (hit_o),
    .we_i        (refill_en_i),
    .wr_idx_i    (victim),
    .wr_ppn_i    (refill_ppn_i),
    .wr_dirty_i  (refill_dirty_i),
    .valid_o     (valid),
    .ref_o       (refs)
  );

  xlat_victim #(.N(N), .REF_W(REF_W)) u_victim (
    .valid_i    (valid),
    .rf_match_i (rf_match),
    .ref_i      (refs),
    .victim_o   (victim)
  );

  assign kern_blk = user_mode_i && vaddr_i[VA_W-1];
  assign any_hit  = |lk_match;
  assign fault_o  = lookup_en_i && kern_blk;
  assign hit_o    = lookup_en_i && !kern_blk && any_hit;
  assign miss_o   = lookup_en_i && !kern_blk && !any_hit;
  assign paddr_o  = hit_o ? {hit_ppn, vaddr_i[OFF_W-1:0]} : '0;
  assign dirty_o  = hit_o && hit_dirty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) restart_q <= 1'b0;
    else         restart_q <= refill_en_i;
  end
  assign restart_o = restart_q;

  assert_flags_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_en_i ? $onehot({hit_o, miss_o, fault_o}) : !(hit_o || miss_o || fault_o));

  assert_offset_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> paddr_o[OFF_W-1:0] == vaddr_i[OFF_W-1:0]);

  assert_restart_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refill_en_i |=> !restart_o);
endmodule

// File: tb/xlat_buf_tb.sv
module xlat_buf_tb;
  localparam int N = 8;
  localparam int REF_W = 3;
  localparam logic [REF_W-1:0] RMAX = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookup_en = 1'b0;
  logic [31:0] vaddr = '0;
  logic        user_mode = 1'b0;
  logic [31:0] paddr;
  logic        hit, miss, fault, dirty, restart;
  logic        refill_en = 1'b0;
  logic [19:0] refill_vpn = '0;
  logic [19:0] refill_ppn = '0;
  logic        refill_dirty = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [19:0]      m_vpn [N];
  logic [19:0]      m_ppn [N];
  logic             m_dty [N];
  logic             m_val [N];
  logic [REF_W-1:0] m_ref [N];

  always #5 clk = ~clk;

  xlat_buf #(.N(N), .REF_W(REF_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lookup_en_i(lookup_en), .vaddr_i(vaddr),
    .user_mode_i(user_mode), .paddr_o(paddr), .hit_o(hit), .miss_o(miss),
    .fault_o(fault), .dirty_o(dirty), .refill_en_i(refill_en),
    .refill_vpn_i(refill_vpn), .refill_ppn_i(refill_ppn),
    .refill_dirty_i(refill_dirty), .restart_o(restart)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int m_find(input logic [19:0] v);
    for (int j = 0; j < N; j++) if (m_val[j] && m_vpn[j] == v) return j;
    return -1;
  endfunction

  function automatic int m_victim(input logic [19:0] v);
    int lo;
    int d;
    d = m_find(v);
    if (d >= 0) return d;
    for (int j = 0; j < N; j++) if (!m_val[j]) return j;
    lo = 0;
    for (int j = 1; j < N; j++) if (m_ref[j] < m_ref[lo]) lo = j;
    return lo;
  endfunction

  task automatic lk(input logic [31:0] va, input logic usr, input string tag);
    int idx;
    bit kb, eh, em;
    logic [31:0] ep;
    @(negedge clk);
    refill_en = 1'b0;
    lookup_en = 1'b1; vaddr = va; user_mode = usr;
    #1;
    kb = usr && va[31];
    idx = m_find(va[31:12]);
    eh = !kb && idx >= 0;
    em = !kb && idx < 0;
    ep = eh ? {m_ppn[idx], va[11:0]} : 32'h0;
    check({hit, miss, fault} == {eh, em, kb}, tag, {hit, miss, fault}, {eh, em, kb});
    check(paddr == ep, tag, paddr, ep);
    check(dirty == (eh && m_dty[idx]), tag, dirty, eh && m_dty[idx]);
    @(posedge clk);
    if (eh)
      for (int j = 0; j < N; j++)
        if (j == idx) m_ref[j] = RMAX;
        else if (m_ref[j] != 0) m_ref[j] = m_ref[j] - 1'b1;
  endtask

  task automatic rf(input logic [19:0] v, input logic [19:0] p, input logic d);
    int w;
    @(negedge clk);
    lookup_en = 1'b0;
    refill_en = 1'b1; refill_vpn = v; refill_ppn = p; refill_dirty = d;
    @(posedge clk);
    w = m_victim(v);
    m_val[w] = 1'b1; m_vpn[w] = v; m_ppn[w] = p; m_dty[w] = d; m_ref[w] = RMAX;
    @(negedge clk);
    refill_en = 1'b0;
    check(restart == 1'b1, "R8 restart after refill", restart, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < N; j++) begin
      m_val[j] = 0; m_vpn[j] = '0; m_ppn[j] = '0; m_dty[j] = 0; m_ref[j] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check({hit, miss, fault, restart} == 4'b0, "R1 idle after reset", {hit, miss, fault, restart}, 0);
    lk(32'h0010_0ABC, 1'b0, "R1 R3 empty buffer misses");

    // R5: no flags when lookup disabled
    @(negedge clk);
    lookup_en = 1'b0; vaddr = 32'h8000_0000; user_mode = 1'b1;
    #1;
    check({hit, miss, fault} == 3'b0, "R5 disabled lookup", {hit, miss, fault}, 0);

    // R2 R7: fill all entries, then translate each with varied offsets
    for (int i = 0; i < N; i++) rf(20'h00100 + 20'(i), 20'h5A000 + 20'(3 * i), i[0]);
    for (int i = 0; i < N; i++) lk({20'h00100 + 20'(i), 12'(i * 12'h111)}, 1'b0, "R2 hit translation");

    // R8: pulse lasts one cycle
    @(negedge clk);
    check(restart == 1'b0, "R8 restart single cycle", restart, 0);

    // R7: refill of resident page overwrites it
    rf(20'h00103, 20'h77777, 1'b1);
    lk(32'h0010_3FFF, 1'b0, "R7 duplicate refill overwrites");

    // R4: kernel page refused in user mode, allowed in kernel mode
    rf(20'h80005, 20'h12345, 1'b0);
    lk(32'h8000_5123, 1'b1, "R4 user fault on kernel hit");
    lk(32'h8000_5123, 1'b0, "R4 kernel mode hits");
    lk(32'h8FFF_F000, 1'b1, "R4 user fault on kernel miss");

    // R6 R7: mixed hits, misses and evictions against the reference model
    for (int k = 0; k < 60; k++) begin
      logic [19:0] v;
      v = 20'h00200 + 20'((k * 7 + k / 5) % 13);
      lk({v, 12'(k * 37)}, 1'b0, "R6 R7 replacement sweep");
      if (m_find(v) < 0) rf(v, 20'hC0000 ^ 20'(v * 5 + k), k[1]);
      if (k % 4 == 0) lk({v, 12'h5A5}, 1'b0, "R3 R6 post-refill lookup");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule